// File: doc/BRIEF.md
# Packed Element Shuffle Network

This block is a purely combinational permutation stage for a packed media datapath. Two 64-bit operands, `vs_i` and `vt_i`, each hold eight bytes or four halfwords. A 4-bit shuffle code chooses one fixed rearrangement, and a size bit chooses the element width where that choice applies. The result appears on `res_o` in the same cycle. The block does no arithmetic and owns no register state.

Element numbering is little-endian. Byte k of an operand occupies bits [8k+7:8k], and halfword k occupies bits [16k+15:16k].

The patterns come in four groups:
- Byte-to-halfword widening: signed or unsigned, taking either the upper or the lower four bytes of `vs_i`.
- Even/odd packing of both operands.
- Interleaving of the upper or lower halves of both operands.
- Four fixed halfword butterfly and replicate patterns.

Any unassigned code gives a zero result and raises `illegal_o`.

Top module: `pshuf_net`

## Requirements
- R1: Codes 0 (upper) and 1 (lower) zero-extend bytes 4..7 or bytes 0..3 of `vs_i`, respectively, into halfwords 0..3 of the result. Byte 4+i (upper) or byte i (lower) goes to halfword i.
- R2: Codes 2 (upper) and 3 (lower) take the same bytes as R1 but sign-extend each byte into its halfword.
- R3: With `hw_i`=0, code 4 puts the even bytes of `vt_i` (0,2,4,6) into result bytes 0..3 and the even bytes of `vs_i` into result bytes 4..7. Code 5 does the same with the odd bytes (1,3,5,7).
- R4: With `hw_i`=1, code 4 gives halfwords {vt0, vt2, vs0, vs2} in result positions 0..3, and code 5 gives {vt1, vt3, vs1, vs3}.
- R5: With `hw_i`=0, code 7 places `vt_i` byte i at result byte 2i and `vs_i` byte i at result byte 2i+1, for i=0..3. Code 6 does the same with source bytes 4+i.
- R6: With `hw_i`=1, code 7 gives halfwords {vt0, vs0, vt1, vs1} in positions 0..3, and code 6 gives {vt2, vs2, vt3, vs3}.
- R7: With `hw_i`=1, code 8 gives halfwords {vt1, vs0, vt3, vs2} in positions 0..3, and code 9 gives {vt3, vs2, vt1, vs0}.
- R8: With `hw_i`=1, code 10 gives halfwords {vt2, vt3, vs2, vs3} in positions 0..3, and code 11 gives {vt0, vt1, vs0, vs1}.
- R9: Codes 12..15, and codes 8..11 with `hw_i`=0, drive `res_o` to zero and `illegal_o` to 1. Every other combination drives `illegal_o` to 0.
- R10: For codes 0..3, `hw_i` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vs_i | input | 64 | First packed source operand |
| vt_i | input | 64 | Second packed source operand |
| code_i | input | 4 | Shuffle code selecting the permutation |
| hw_i | input | 1 | Element size: 0 = byte, 1 = halfword (pack, mix, butterfly, replicate) |
| res_o | output | 64 | Permuted result |
| illegal_o | output | 1 | High when the code and size combination is undefined |

## Verification
The operands are chosen so that every byte is distinct and several bytes have bit 7 set. A swapped index, a wrong half, or a wrong extension therefore shows up as a different value in the result. Sign extension is probed with 0x7F, 0x80, 0xFF and 0x00 bytes: a design that extends from the wrong bit, or that confuses the signed and unsigned codes, produces 0x00 where 0xFF belongs. Butterfly and replicate codes are also driven with the byte size, and the undefined codes 12..15 are driven as well. A decoder that lets these through leaks operand data onto `res_o` instead of zero and leaves `illegal_o` low. The widening codes are repeated with `hw_i` set, to catch a design that lets the size bit disturb them.

// File: rtl/pshuf_net.sv
module pshuf_net (
  input  logic [63:0] vs_i,
  input  logic [63:0] vt_i,
  input  logic [3:0]  code_i,
  input  logic        hw_i,
  output logic [63:0] res_o,
  output logic        illegal_o
);
  localparam int NB = 8;
  localparam int NH = 4;

  logic [63:0] perm;
  logic        bad;
  logic [7:0]  src_b;

  always_comb begin
    perm  = '0;
    bad   = 1'b0;
    src_b = '0;
    case (code_i)
      4'd0, 4'd1, 4'd2, 4'd3: begin
        for (int i = 0; i < NH; i++) begin
          src_b = vs_i[8*(i + (code_i[0] ? 0 : NB/2)) +: 8];
          perm[16*i +: 16] = {(code_i[1] ? {8{src_b[7]}} : 8'h00), src_b};
        end
      end
      4'd4, 4'd5: begin
        if (!hw_i) begin
          for (int i = 0; i < NB/2; i++) begin
            perm[8*i +: 8]          = vt_i[8*(2*i + int'(code_i[0])) +: 8];
            perm[8*(i+NB/2) +: 8]   = vs_i[8*(2*i + int'(code_i[0])) +: 8];
          end
        end else begin
          for (int i = 0; i < NH/2; i++) begin
            perm[16*i +: 16]        = vt_i[16*(2*i + int'(code_i[0])) +: 16];
            perm[16*(i+NH/2) +: 16] = vs_i[16*(2*i + int'(code_i[0])) +: 16];
          end
        end
      end
      4'd6, 4'd7: begin
        if (!hw_i) begin
          for (int i = 0; i < NB/2; i++) begin
            perm[16*i +: 8]     = vt_i[8*(i + (code_i[0] ? 0 : NB/2)) +: 8];
            perm[16*i+8 +: 8]   = vs_i[8*(i + (code_i[0] ? 0 : NB/2)) +: 8];
          end
        end else begin
          for (int i = 0; i < NH/2; i++) begin
            perm[32*i +: 16]    = vt_i[16*(i + (code_i[0] ? 0 : NH/2)) +: 16];
            perm[32*i+16 +: 16] = vs_i[16*(i + (code_i[0] ? 0 : NH/2)) +: 16];
          end
        end
      end
      4'd8:  perm = {vs_i[47:32], vt_i[63:48], vs_i[15:0],  vt_i[31:16]};
      4'd9:  perm = {vs_i[15:0],  vt_i[31:16], vs_i[47:32], vt_i[63:48]};
      4'd10: perm = {vs_i[63:32], vt_i[63:32]};
      4'd11: perm = {vs_i[31:0],  vt_i[31:0]};
      default: bad = 1'b1;
    endcase
    if (code_i[3] && !hw_i) bad = 1'b1;
  end

  assign illegal_o = bad;
  assign res_o     = bad ? 64'h0 : perm;
endmodule

module pshuf_net_chk (
  input logic [63:0] vs_i,
  input logic [63:0] vt_i,
  input logic [3:0]  code_i,
  input logic        hw_i,
  input logic [63:0] res_o,
  input logic        illegal_o
);
  always_comb begin
    if (!$isunknown({vs_i, vt_i, code_i, hw_i})) begin
      AST_ILLEGAL_ZERO: assert (!illegal_o || res_o == 64'h0);                       // R9
      AST_HIGH_CODE_BAD: assert (code_i < 4'd12 || illegal_o);                       // R9
      AST_UNPK_ZEXT: assert (code_i > 4'd1 ||
        (res_o[15:8] == 8'h0 && res_o[31:24] == 8'h0 &&
         res_o[47:40] == 8'h0 && res_o[63:56] == 8'h0));                             // R1
      AST_UNPK_SEXT: assert (code_i != 4'd3 ||
        (res_o[15:8] == {8{vs_i[7]}} && res_o[63:56] == {8{vs_i[31]}}));             // R2
      AST_MIX_LO_BYTE: assert (code_i != 4'd7 || hw_i ||
        (res_o[7:0] == vt_i[7:0] && res_o[15:8] == vs_i[7:0]));                      // R5
      AST_REP_UPPER: assert (code_i != 4'd10 || !hw_i || res_o[63:32] == vs_i[63:32]); // R8
    end
  end
endmodule

bind pshuf_net pshuf_net_chk chk_i (
  .vs_i(vs_i), .vt_i(vt_i), .code_i(code_i), .hw_i(hw_i),
  .res_o(res_o), .illegal_o(illegal_o)
);

// File: tb/pshuf_net_tb.sv
module pshuf_net_tb_top;
  logic clk = 1'b0;
  logic [63:0] vs = '0, vt = '0;
  logic [3:0]  code = '0;
  logic        hw = 1'b0;
  logic [63:0] res;
  logic        ill;
  int n_chk = 0, n_bad = 0;

  localparam logic [63:0] VS_A = 64'h8776655443322190;
  localparam logic [63:0] VT_A = 64'h0FEDCBA978563412;

  always #2 clk = ~clk;

  pshuf_net dut_i (.vs_i(vs), .vt_i(vt), .code_i(code), .hw_i(hw),
                   .res_o(res), .illegal_o(ill));

  task automatic apply(input logic [63:0] a, input logic [63:0] b,
                       input logic [3:0] c, input logic h);
    @(posedge clk);
    vs = a; vt = b; code = c; hw = h;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] got_r, input logic [63:0] exp_r,
                       input logic got_i, input logic exp_i);
    n_chk++;
    if (got_r !== exp_r || got_i !== exp_i) begin
      n_bad++;
      $display("FAIL %s code=%0d hw=%0b: got %h/%0b expected %h/%0b",
               req, code, hw, got_r, got_i, exp_r, exp_i);
    end
  endtask

  task automatic t_idle;
    apply(64'h0, 64'h0, 4'd0, 1'b0);
    check("R1 idle", res, 64'h0, ill, 1'b0);
  endtask

  task automatic t_unpack_unsigned;
    apply(VS_A, VT_A, 4'd0, 1'b0); check("R1 hi", res, 64'h0087007600650054, ill, 1'b0);
    apply(VS_A, VT_A, 4'd1, 1'b0); check("R1 lo", res, 64'h0043003200210090, ill, 1'b0);
    apply(64'h7F80FF0001FE807F, VT_A, 4'd1, 1'b0);
    check("R1 lo edge", res, 64'h000100FE0080007F, ill, 1'b0);
  endtask

  task automatic t_unpack_signed;
    apply(VS_A, VT_A, 4'd2, 1'b0); check("R2 hi", res, 64'hFF87007600650054, ill, 1'b0);
    apply(VS_A, VT_A, 4'd3, 1'b0); check("R2 lo", res, 64'h004300320021FF90, ill, 1'b0);
    apply(64'h7F80FF0001FE807F, VT_A, 4'd3, 1'b0);
    check("R2 lo edge", res, 64'h0001FFFEFF80007F, ill, 1'b0);
    apply(64'h7F80FF0001FE807F, VT_A, 4'd2, 1'b0);
    check("R2 hi edge", res, 64'h007FFF80FFFF0000, ill, 1'b0);
  endtask

  task automatic t_unpack_size_ignored;
    apply(VS_A, VT_A, 4'd0, 1'b1); check("R10 uh", res, 64'h0087007600650054, ill, 1'b0);
    apply(VS_A, VT_A, 4'd3, 1'b1); check("R10 sl", res, 64'h004300320021FF90, ill, 1'b0);
  endtask

  task automatic t_pack;
    apply(VS_A, VT_A, 4'd4, 1'b0); check("R3 even", res, 64'h76543290EDA95612, ill, 1'b0);
    apply(VS_A, VT_A, 4'd5, 1'b0); check("R3 odd",  res, 64'h876543210FCB7834, ill, 1'b0);
    apply(VS_A, VT_A, 4'd4, 1'b1); check("R4 even", res, 64'h65542190CBA93412, ill, 1'b0);
    apply(VS_A, VT_A, 4'd5, 1'b1); check("R4 odd",  res, 64'h877643320FED7856, ill, 1'b0);
  endtask

  task automatic t_mix;
    apply(VS_A, VT_A, 4'd7, 1'b0); check("R5 lo", res, 64'h4378325621349012, ill, 1'b0);
    apply(VS_A, VT_A, 4'd6, 1'b0); check("R5 hi", res, 64'h870F76ED65CB54A9, ill, 1'b0);
    apply(VS_A, VT_A, 4'd7, 1'b1); check("R6 lo", res, 64'h4332785621903412, ill, 1'b0);
    apply(VS_A, VT_A, 4'd6, 1'b1); check("R6 hi", res, 64'h87760FED6554CBA9, ill, 1'b0);
  endtask

  task automatic t_bfly_rep;
    apply(VS_A, VT_A, 4'd8,  1'b1); check("R7 A", res, 64'h65540FED21907856, ill, 1'b0);
    apply(VS_A, VT_A, 4'd9,  1'b1); check("R7 B", res, 64'h2190785665540FED, ill, 1'b0);
    apply(VS_A, VT_A, 4'd10, 1'b1); check("R8 A", res, 64'h877665540FEDCBA9, ill, 1'b0);
    apply(VS_A, VT_A, 4'd11, 1'b1); check("R8 B", res, 64'h4332219078563412, ill, 1'b0);
  endtask

  task automatic t_illegal;
    for (int c = 12; c < 16; c++) begin
      apply(VS_A, VT_A, c[3:0], 1'b1); check("R9 undefined", res, 64'h0, ill, 1'b1);
    end
    for (int c = 8; c < 12; c++) begin
      apply(VS_A, VT_A, c[3:0], 1'b0); check("R9 byte size", res, 64'h0, ill, 1'b1);
    end
  endtask

  initial begin
    #40000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_idle();
    t_unpack_unsigned();
    t_unpack_signed();
    t_unpack_size_ignored();
    t_pack();
    t_mix();
    t_bfly_rep();
    t_illegal();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule